// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer behind a small byte-addressed register bus. A prescaler divides the clock into ticks, and each tick steps a 10-bit down-counter. Software sets the initial value, starts or halts the count, and restarts the count by writing the reload register. If software stops writing it, the counter runs out.

Expiry happens in two stages. The first underflow latches a first-timeout flag and reloads the counter. If the counter runs out again while that flag is still set, the block sets a second-timeout flag and a boot flag. It then sends a single-cycle reset request and stops counting. A no-reboot control bit can mask that request, and the flags still update when it does. Software clears the status flags by writing 1s to them.

Each bus access is either one byte or one 16-bit word. A word access uses the even address of its pair, and bit 0 of the address is ignored. A byte access reads or writes only the lane that the address selects. Reads are combinational.

Top module: `wdt_two_stage`

## Requirements
- R1: Out of reset, the register reads are as follows: control 1 (0x08) reads 0x0800, the initial-value register (0x12) reads 0x0004, control 2 (0x0A) reads 0x0001, both status registers read 0, the reload register reads 0x0004, and `rst_req` is 0.
- R2: A word access covers both bytes of the pair at the even address. A byte access at an even address uses bits 7:0 of the word, and at an odd address it uses bits 15:8. Byte read data appears on `bus_rdata[7:0]` with zeros above it. Offset 0x03 is a writable data-out byte, and offset 0x02 always reads 0.
- R3: Bits 9:0 of offset 0x12 hold the initial value. If a write would leave that field below 4, the field keeps its old value. Bits 15:10 are plain read/write storage.
- R4: Any write to offset 0x00 loads the counter with the initial value and restarts the prescaler. A read of 0x00 returns the count in bits 9:0, with bits 15:10 reading 0.
- R5: When bit 11 of control 1 is 0, the counter steps down by one every `TICK_CYCLES` clocks. When that bit is 1, the count holds.
- R6: A tick that finds the count at 0 with the first-timeout flag clear is a first underflow. It sets status 1 bit 3 and reloads the initial value. After a reload of N, the first underflow comes (N+1)·`TICK_CYCLES` clocks later.
- R7: A tick that finds the count at 0 with the first-timeout flag set is a second underflow. It sets status 2 bit 1 (second timeout) and bit 2 (boot). In the same cycle it raises `rst_req` for exactly one cycle. The count then holds at 0 until the next reload write.
- R8: When control 2 bit 0 (no-reboot) is 1, `rst_req` stays 0, but the status flags still update.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If the first-timeout flag is cleared between the two underflows, the next underflow counts as a first underflow again.
- R10: Bit 8 of control 1 reads back the value last written to it and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (a byte write uses bits 7:0) |
| bus_rdata | output | 16 | Combinational read data |
| rst_req | output | 1 | Single-cycle reset request on a second underflow |

## Verification
The initial-value register receives random words and random bytes on either lane. Some of these values fall below the floor of 4, which tells ignored field updates apart from accepted lane merges. Random writes to the control scratch bit and the data byte separate the effect of the word lanes from that of the byte lanes. Directed runs then time the underflows to the exact cycle. They cover three cases: an uninterrupted double expiry, an expiry where the first flag is cleared between underflows (no reset), and an expiry with no-reboot set (flags update, no request).

// File: rtl/wdt_pkg.sv
// Shared constants for the two-stage watchdog: register offsets, bit
// positions and counter sizing. Assumes a 5-bit byte address space.
package wdt_pkg;
    localparam int CNT_W    = 10;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_STS1   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STS2   = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTL1   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL2   = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

    localparam int BIT_FIRST    = 3;   // status 1
    localparam int BIT_SECOND   = 1;   // status 2
    localparam int BIT_BOOT     = 2;   // status 2
    localparam int BIT_HALT     = 11;  // control 1
    localparam int BIT_SCRATCH  = 8;   // control 1
    localparam int BIT_NOREBOOT = 0;   // control 2

    localparam logic [CNT_W-1:0] INIT_MIN   = 10'd4;
    localparam logic [CNT_W-1:0] INIT_RESET = 10'd4;
endpackage

// File: rtl/wdt_prescaler.sv
// Tick prescaler: emits a one-cycle tick every TICK_CYCLES clocks while
// run is high. Holds its phase while stopped; restart zeroes the phase.
module wdt_prescaler #(
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase;

    // Phase counter: wraps at LAST, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (restart)      phase <= '0;
        else if (run) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

    assign tick = run && !restart && (phase == LAST);
endmodule

// File: rtl/wdt_counter.sv
// Down-counter with two-stage expiry. A tick at zero is a first underflow
// (reload) when first_flag is clear, else a second underflow (stop).
// Assumes tick never arrives while stopped (the top gates the prescaler).
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    input  logic             first_flag,
    output logic [CNT_W-1:0] count,
    output logic             stopped,
    output logic             first_uf,
    output logic             second_uf
);
    logic at_zero_tick;

    assign at_zero_tick = tick && (count == '0);
    assign first_uf     = at_zero_tick && !first_flag;
    assign second_uf    = at_zero_tick &&  first_flag;

    // Count and stop state: reload has priority over any tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= INIT_RESET;
            stopped <= 1'b0;
        end else if (reload) begin
            count   <= init_val;
            stopped <= 1'b0;
        end else if (second_uf) begin
            stopped <= 1'b1;
        end else if (first_uf) begin
            count   <= init_val;
        end else if (tick) begin
            count   <= count - 1'b1;
        end
    end

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !reload |=> $stable(count));  // R7
    AST_SECOND_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        second_uf && !reload |=> stopped && count == '0);  // R7
endmodule

// File: rtl/wdt_regs.sv
// Register file and bus decode. Handles byte/word lanes, the initial-value
// floor, write-1-to-clear status and combinational read data. Assumes
// bus_wr is a one-cycle strobe; hardware flag sets win over clears.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              first_uf,
    input  logic              second_uf,
    output logic [CNT_W-1:0]  init_val,
    output logic              halt,
    output logic              no_reboot,
    output logic              first_flag,
    output logic              reload
);
    localparam int WORD_W = ADDR_W - 1;

    logic [WORD_W-1:0] word_sel;
    logic              wr_lo, wr_hi;
    logic [7:0]        lo_byte, hi_byte;
    logic [DATA_W-1:0] wmask, wval, init_cand, word_rd;
    logic [DATA_W-1:0] init_q;
    logic              scratch, second_flag, boot_flag;
    logic [7:0]        data_out;
    logic              clr_first, clr_second, clr_boot;

    assign word_sel  = bus_addr[ADDR_W-1:1];
    assign wr_lo     = bus_wr && (bus_wide || !bus_addr[0]);
    assign wr_hi     = bus_wr && (bus_wide ||  bus_addr[0]);
    assign lo_byte   = bus_wdata[7:0];
    assign hi_byte   = bus_wide ? bus_wdata[15:8] : bus_wdata[7:0];
    assign wmask     = {{8{wr_hi}}, {8{wr_lo}}};
    assign wval      = {hi_byte, lo_byte};
    assign init_cand = (init_q & ~wmask) | (wval & wmask);

    assign reload     = bus_wr && (word_sel == OFS_RELOAD[ADDR_W-1:1]);
    assign clr_first  = wr_lo && (word_sel == OFS_STS1[ADDR_W-1:1]) && lo_byte[BIT_FIRST];
    assign clr_second = wr_lo && (word_sel == OFS_STS2[ADDR_W-1:1]) && lo_byte[BIT_SECOND];
    assign clr_boot   = wr_lo && (word_sel == OFS_STS2[ADDR_W-1:1]) && lo_byte[BIT_BOOT];

    // Initial-value register: upper bits plain storage, field floored at 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= {{(DATA_W-CNT_W){1'b0}}, INIT_RESET};
        end else if (bus_wr && word_sel == OFS_INIT[ADDR_W-1:1]) begin
            init_q[DATA_W-1:CNT_W] <= init_cand[DATA_W-1:CNT_W];
            if (init_cand[CNT_W-1:0] >= INIT_MIN)
                init_q[CNT_W-1:0] <= init_cand[CNT_W-1:0];
        end
    end

    // Control bits and the data-out byte, all in their own lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt      <= 1'b1;
            scratch   <= 1'b0;
            no_reboot <= 1'b1;
            data_out  <= '0;
        end else begin
            if (wr_hi && word_sel == OFS_CTL1[ADDR_W-1:1]) begin
                halt    <= hi_byte[BIT_HALT-8];
                scratch <= hi_byte[BIT_SCRATCH-8];
            end
            if (wr_lo && word_sel == OFS_CTL2[ADDR_W-1:1])
                no_reboot <= lo_byte[BIT_NOREBOOT];
            if (wr_hi && word_sel == OFS_DATA[ADDR_W-1:1])
                data_out <= hi_byte;
        end
    end

    // Status flags: set by the counter, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_flag  <= 1'b0;
            second_flag <= 1'b0;
            boot_flag   <= 1'b0;
        end else begin
            if (first_uf)        first_flag <= 1'b1;
            else if (clr_first)  first_flag <= 1'b0;
            if (second_uf)       second_flag <= 1'b1;
            else if (clr_second) second_flag <= 1'b0;
            if (second_uf)       boot_flag <= 1'b1;
            else if (clr_boot)   boot_flag <= 1'b0;
        end
    end

    // Read word selection by address pair.
    always_comb begin
        word_rd = '0;
        case (word_sel)
            OFS_RELOAD[ADDR_W-1:1]: word_rd[CNT_W-1:0] = count;
            OFS_DATA[ADDR_W-1:1]:   word_rd[15:8] = data_out;
            OFS_STS1[ADDR_W-1:1]:   word_rd[BIT_FIRST] = first_flag;
            OFS_STS2[ADDR_W-1:1]: begin
                word_rd[BIT_SECOND] = second_flag;
                word_rd[BIT_BOOT]   = boot_flag;
            end
            OFS_CTL1[ADDR_W-1:1]: begin
                word_rd[BIT_HALT]    = halt;
                word_rd[BIT_SCRATCH] = scratch;
            end
            OFS_CTL2[ADDR_W-1:1]:   word_rd[BIT_NOREBOOT] = no_reboot;
            OFS_INIT[ADDR_W-1:1]:   word_rd = init_q;
            default:                word_rd = '0;
        endcase
    end

    // Lane steering of read data for byte accesses.
    always_comb begin
        if (bus_wide)         bus_rdata = word_rd;
        else if (bus_addr[0]) bus_rdata = {8'h00, word_rd[15:8]};
        else                  bus_rdata = {8'h00, word_rd[7:0]};
    end

    assign init_val = init_q[CNT_W-1:0];

    AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        init_q[CNT_W-1:0] >= INIT_MIN);  // R3
    AST_BOOT_WITH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_flag) |-> boot_flag);  // R7
    AST_ZERO_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        first_flag && !clr_first |=> first_flag);  // R9
endmodule

// File: rtl/wdt_two_stage.sv
// Top of the two-stage watchdog: ties the register file, prescaler and
// counter together and registers the masked reset request. Assumes a
// single clock domain with a synchronous active-low reset.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic [CNT_W-1:0] init_val, count;
    logic halt, no_reboot, first_flag, reload;
    logic stopped, first_uf, second_uf, tick, run;

    assign run = !halt && !stopped;

    wdt_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .first_uf(first_uf), .second_uf(second_uf),
        .init_val(init_val), .halt(halt), .no_reboot(no_reboot),
        .first_flag(first_flag), .reload(reload)
    );

    wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(reload), .tick(tick)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
        .init_val(init_val), .first_flag(first_flag), .count(count),
        .stopped(stopped), .first_uf(first_uf), .second_uf(second_uf)
    );

    // Reset request: one cycle per second underflow, masked by no-reboot.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= second_uf && !no_reboot;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);  // R7
    AST_NOREBOOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(no_reboot));  // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !reload |=> $stable(count));  // R5
endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
    localparam int T = 4;
    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [15:0] rd;
    logic [15:0] init_model;

    wdt_two_stage #(.TICK_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic wide);
        bus_addr = a; bus_wdata = d; bus_wide = wide; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [4:0] a, input logic wide, output logic [15:0] d);
        bus_addr = a; bus_wide = wide;
        #2;
        d = bus_rdata;
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Expected initial-value register after a write (R2 lanes, R3 floor).
    function automatic logic [15:0] exp_init(input logic [15:0] old, input logic a0,
                                             input logic [15:0] d, input logic wide);
        logic [15:0] m, v, c;
        if (wide)    begin m = 16'hFFFF; v = d; end
        else if (a0) begin m = 16'hFF00; v = {d[7:0], 8'h00}; end
        else         begin m = 16'h00FF; v = {8'h00, d[7:0]}; end
        c = (old & ~m) | (v & m);
        return (c[9:0] >= 10'd4) ? c : {c[15:10], old[9:0]};
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        logic [15:0] d;
        logic b;
        void'($urandom(32'd4711));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rdreg(5'h08, 1, rd); check("R1 ctl1", rd, 16'h0800);
        rdreg(5'h12, 1, rd); check("R1 init", rd, 16'h0004);
        rdreg(5'h0A, 1, rd); check("R1 ctl2", rd, 16'h0001);
        rdreg(5'h04, 1, rd); check("R1 sts1", rd, 16'h0000);
        rdreg(5'h06, 1, rd); check("R1 sts2", rd, 16'h0000);
        rdreg(5'h00, 1, rd); check("R1 count", rd, 16'h0004);
        check("R1 rst_req", {15'b0, rst_req}, 16'h0000);

        // R3 directed: floor and upper storage
        init_model = 16'h0004;
        wr(5'h12, 16'h0003, 1); rdreg(5'h12, 1, rd); check("R3 below floor", rd, 16'h0004);
        wr(5'h12, 16'h0004, 1); rdreg(5'h12, 1, rd); check("R3 at floor", rd, 16'h0004);
        wr(5'h12, 16'hFC07, 1); rdreg(5'h12, 1, rd); check("R3 upper bits", rd, 16'hFC07);
        wr(5'h12, 16'h0000, 1); rdreg(5'h12, 1, rd); check("R3 zero ignored", rd, 16'h0007);
        // R2 byte lanes on the initial-value register
        wr(5'h13, 16'h0001, 0); rdreg(5'h12, 1, rd); check("R2 high lane", rd, 16'h0107);
        wr(5'h12, 16'h0002, 0); rdreg(5'h12, 1, rd); check("R2 low lane", rd, 16'h0102);
        rdreg(5'h13, 0, rd); check("R2 byte read hi", rd, 16'h0001);
        init_model = 16'h0102;

        // R3 random writes against the model
        for (int i = 0; i < 24; i++) begin
            d = 16'($urandom);
            if ($urandom_range(0, 2) == 0) d[9:0] = 10'($urandom_range(0, 3));
            b = 1'($urandom);
            if (b) begin
                wr(5'h12, d, 1);
                init_model = exp_init(init_model, 1'b0, d, 1'b1);
            end else begin
                logic a0;
                a0 = 1'($urandom);
                wr({4'h9, a0}, d, 0);
                init_model = exp_init(init_model, a0, d, 1'b0);
            end
            rdreg(5'h12, 1, rd); check("R3 random init", rd, init_model);
        end

        // R2 / R10 random control scratch and data byte (counter halted)
        for (int i = 0; i < 12; i++) begin
            logic s;
            logic [7:0] db;
            s  = 1'($urandom);
            db = 8'($urandom);
            wr(5'h08, {4'b0000, 1'b1, 2'b00, s, 8'($urandom)}, 1);
            rdreg(5'h08, 1, rd); check("R10 scratch readback", rd, {4'b0, 1'b1, 2'b0, s, 8'h00});
            wr(5'h03, {8'h00, db}, 0);
            rdreg(5'h03, 0, rd); check("R2 data-out byte", rd, {8'h00, db});
            rdreg(5'h02, 0, rd); check("R2 data-in zero", rd, 16'h0000);
            rdreg(5'h02, 1, rd); check("R2 data word", rd, {db, 8'h00});
        end

        // R5 halted: count holds; R10 scratch has no effect
        wr(5'h12, 16'(N), 1);
        wr(5'h00, 16'h0001, 1);
        rdreg(5'h00, 1, rd); check("R4 reload loads init", rd, 16'(N));
        wr(5'h08, 16'h0900, 1);
        step(5 * T);
        rdreg(5'h00, 1, rd); check("R5 halt holds / R10", rd, 16'(N));

        // R4..R7 full two-stage expiry
        wr(5'h0A, 16'h0000, 1);
        wr(5'h08, 16'h0000, 1);
        p0 = pulses;
        wr(5'h00, 16'h0000, 1);               // reload at edge E0
        step(T - 1);
        rdreg(5'h00, 1, rd); check("R5 before first tick", rd, 16'(N));
        step(1);
        rdreg(5'h00, 1, rd); check("R5 one tick", rd, 16'(N - 1));
        step(N * T - 1);
        rdreg(5'h04, 1, rd); check("R6 not yet", rd, 16'h0000);
        step(1);
        rdreg(5'h04, 1, rd); check("R6 first flag", rd, 16'h0008);
        rdreg(5'h00, 1, rd); check("R6 reloaded", rd, 16'(N));
        step((N + 1) * T - 1);
        check("R7 no request early", {15'b0, rst_req}, 16'h0000);
        step(1);
        check("R7 request", {15'b0, rst_req}, 16'h0001);
        rdreg(5'h06, 1, rd); check("R7 second+boot", rd, 16'h0006);
        step(1);
        check("R7 one cycle", {15'b0, rst_req}, 16'h0000);
        step(3 * T);
        rdreg(5'h00, 1, rd); check("R7 stopped at zero", rd, 16'h0000);
        check("R7 single pulse", 16'(pulses - p0), 16'h0001);

        // R9 write-1-to-clear
        wr(5'h06, 16'h0000, 1); rdreg(5'h06, 1, rd); check("R9 zero no effect", rd, 16'h0006);
        wr(5'h06, 16'h0002, 0); rdreg(5'h06, 1, rd); check("R9 clear second", rd, 16'h0004);
        wr(5'h04, 16'h0000, 1); rdreg(5'h04, 1, rd); check("R9 zero keeps first", rd, 16'h0008);
        wr(5'h04, 16'h0008, 1); rdreg(5'h04, 1, rd); check("R9 clear first", rd, 16'h0000);
        wr(5'h06, 16'h0004, 1); rdreg(5'h06, 1, rd); check("R9 clear boot", rd, 16'h0000);

        // R9 clearing first flag between underflows restarts two-stage
        p0 = pulses;
        wr(5'h00, 16'h0000, 1);
        step((N + 1) * T);
        rdreg(5'h04, 1, rd); check("R9 first again", rd, 16'h0008);
        wr(5'h04, 16'h0008, 1);
        step((N + 1) * T - 1);
        rdreg(5'h04, 1, rd); check("R9 re-armed first", rd, 16'h0008);
        rdreg(5'h06, 1, rd); check("R9 no second", rd, 16'h0000);
        check("R9 no request", 16'(pulses - p0), 16'h0000);
        wr(5'h08, 16'h0800, 1);
        wr(5'h04, 16'h0008, 1);

        // R8 no-reboot masks the request, flags still update
        wr(5'h0A, 16'h0001, 1);
        wr(5'h08, 16'h0000, 1);
        p0 = pulses;
        wr(5'h00, 16'h0000, 1);
        step(2 * (N + 1) * T + 2);
        rdreg(5'h06, 1, rd); check("R8 flags set", rd, 16'h0006);
        rdreg(5'h04, 1, rd); check("R8 first set", rd, 16'h0008);
        check("R8 request masked", 16'(pulses - p0), 16'h0000);
        rdreg(5'h00, 1, rd); check("R8 stopped", rd, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule